// File: doc/BRIEF.md
# Serial Configuration Command Decoder

This block terminates a two-wire serial configuration link. A qualifier line (`shift_ctl`) frames each command and a data line (`shift_in`) carries it. Both are timed by one bus clock: the qualifier is sampled on rising edges and the data bit on falling edges. Each frame starts with a 13-bit header. The decoder checks the header against the chip's identity and against a table of legal register/instruction pairs. It then drives single-cycle strobes to a separate register bank.

Write payloads are not buffered here. Each payload bit goes to the bank as a one-cycle `wr_en` pulse, and the final bit of the register's length is flagged with `wr_last`. For reads, the decoder raises `rd_req`. It then paces the bank with `rd_adv` and retimes the bank's serial answer onto `shift_out` for as long as the qualifier stays high.

One command, a set aimed at the time-stamp capture register (15), is not executed at the header. It fires as `acq_stb` on the first falling edge after the qualifier has been released.

Top module: `cmd_link_decoder`

## Requirements
- R1: A header is 13 bits sent most significant bit first: chip address in bits 12..8, register number in bits 7..3, instruction in bits 2..0. On every accepted header, `reg_sel` carries the register number.
- R2: A header is accepted when its address is 10101, or when it equals `chip_id` with `id_bonded` high, or when it equals 01010 with `id_bonded` low. Any other address produces no output activity.
- R3: Instruction 010 (set), 101 (clear) and 110 (default) each raise `set_stb`, `clr_stb` or `dflt_stb` for exactly one cycle. That cycle starts at the first rising edge after the falling edge that captured header bit 0. At most one action output is high in any cycle.
- R4: Instruction 001 (write) is followed by payload bits. Register 16 takes 2 bits, registers 17 and 18 take ARRAY_BITS bits, and registers 1–7 and 9–15 take 8 bits. Each captured payload bit gives a one-cycle `wr_en` with the bit on `wr_bit`, one cycle after its falling-edge capture. `wr_last` marks the final bit, and bits beyond the length are ignored.
- R5: Instruction 100 (read) raises `rd_req` in the strobe cycle of R3. `rd_adv` is high from the next cycle for as long as the qualifier remains high. `shift_out` presents `rd_bit` one cycle after each cycle in which `rd_adv` is high.
- R6: A set to register 15 raises no `set_stb`. Instead, `acq_stb` goes high for one clock period starting at the first falling edge at which the qualifier, sampled at the preceding rising edge, is low.
- R7: Lowering the qualifier discards a partly received header or payload. The next frame is decoded from its first bit.
- R8: Registers 0, 8, 22, 23, 25–27 and 29–31 are no-ops. Registers 19 and 20 accept only set, clear and default. Register 21 (broadcast target) accepts only set, clear and default. Registers 24 and 28 accept only set.
- R9: Instruction codes 000, 011 and 111 produce no output activity.
- R10: While reset is asserted, every output is low.
- R11: `shift_out` is low whenever no read response is being forwarded, including after the qualifier drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_ctl | input | 1 | Frame qualifier, sampled on rising edges |
| shift_in | input | 1 | Serial command data, sampled on falling edges |
| chip_id | input | ADDR_W | Strapped chip address |
| id_bonded | input | 1 | High when `chip_id` is valid; low selects 01010 |
| rd_bit | input | 1 | Current read-response bit from the register bank |
| reg_sel | output | 5 | Register number of the last accepted header |
| set_stb | output | 1 | Set-all-ones strobe |
| clr_stb | output | 1 | Clear-to-zero strobe |
| dflt_stb | output | 1 | Load-default strobe |
| wr_en | output | 1 | Write payload bit valid |
| wr_bit | output | 1 | Write payload bit value |
| wr_last | output | 1 | Final payload bit for the target register |
| rd_req | output | 1 | Read request, one cycle |
| rd_adv | output | 1 | Bank advances its response on each rising edge while high |
| shift_out | output | 1 | Serial read response |
| acq_stb | output | 1 | Deferred time-stamp capture strobe |

## Verification
The bench attacks the edge pairing. A design that sampled data on the wrong edge, or decoded one bit early, would place every strobe a cycle off, or latch a shifted register number into `reg_sel`. It targets the deferred capture, which a wrong design would fire at the header or not at all. It also targets payload lengths: a write that is overrun, or cut short by an early qualifier drop, must stop or truncate instead of spilling `wr_en` pulses past the register length. Address straps, no-op registers, illegal instruction/register pairs and aborted headers must leave every output quiet. A decoder with a stale bit counter would instead misread the frame that follows.

// File: rtl/cmd_link_decoder.sv
module cmd_link_decoder #(
  parameter int ADDR_W = 5,
  parameter int ARRAY_BITS = 2816,
  parameter int BYTE_BITS = 8,
  parameter int MODE_BITS = 2,
  parameter logic [ADDR_W-1:0] BCAST_ID = 5'b10101,
  parameter logic [ADDR_W-1:0] FLOAT_ID = 5'b01010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_ctl,
  input  logic              shift_in,
  input  logic [ADDR_W-1:0] chip_id,
  input  logic              id_bonded,
  input  logic              rd_bit,
  output logic [4:0]        reg_sel,
  output logic              set_stb,
  output logic              clr_stb,
  output logic              dflt_stb,
  output logic              wr_en,
  output logic              wr_bit,
  output logic              wr_last,
  output logic              rd_req,
  output logic              rd_adv,
  output logic              shift_out,
  output logic              acq_stb
);
  localparam int REG_W    = 5;
  localparam int OP_W     = 3;
  localparam int HDR_BITS = ADDR_W + REG_W + OP_W;
  localparam int CNT_W    = $clog2(HDR_BITS + 1);
  localparam int DCNT_W   = $clog2(ARRAY_BITS + 1);
  localparam logic [OP_W-1:0] OP_WRITE = 3'b001;
  localparam logic [OP_W-1:0] OP_SET   = 3'b010;
  localparam logic [OP_W-1:0] OP_READ  = 3'b100;
  localparam logic [OP_W-1:0] OP_CLR   = 3'b101;
  localparam logic [OP_W-1:0] OP_DFLT  = 3'b110;
  localparam logic [REG_W-1:0] CAP_REG = 5'd15;

  typedef enum logic [2:0] {K_NONE, K_BYTE, K_MODE, K_ARRAY, K_FLAG, K_BCAST, K_ACTION} kind_e;

  function automatic kind_e kind_of(input logic [REG_W-1:0] r);
    if ((r >= 5'd1 && r <= 5'd7) || (r >= 5'd9 && r <= 5'd15)) return K_BYTE;
    if (r == 5'd16) return K_MODE;
    if (r == 5'd17 || r == 5'd18) return K_ARRAY;
    if (r == 5'd19 || r == 5'd20) return K_FLAG;
    if (r == 5'd21) return K_BCAST;
    if (r == 5'd24 || r == 5'd28) return K_ACTION;
    return K_NONE;
  endfunction

  function automatic logic legal(input kind_e k, input logic [OP_W-1:0] op);
    case (k)
      K_BYTE, K_MODE, K_ARRAY:
        return op == OP_WRITE || op == OP_SET || op == OP_READ || op == OP_CLR || op == OP_DFLT;
      K_FLAG, K_BCAST:
        return op == OP_SET || op == OP_CLR || op == OP_DFLT;
      K_ACTION:
        return op == OP_SET;
      default:
        return 1'b0;
    endcase
  endfunction

  function automatic logic [DCNT_W-1:0] len_of(input kind_e k);
    case (k)
      K_BYTE:  return DCNT_W'(BYTE_BITS);
      K_MODE:  return DCNT_W'(MODE_BITS);
      K_ARRAY: return DCNT_W'(ARRAY_BITS);
      default: return '0;
    endcase
  endfunction

  logic                  sc_r;
  logic [CNT_W-1:0]      hcnt;
  logic [HDR_BITS-2:0]   hsr;
  logic [DCNT_W-1:0]     dcnt, dlen;
  logic [REG_W-1:0]      hreg;
  logic [OP_W-1:0]       hop;
  logic                  hdr_new, dat_new, dat_bit, dat_last, wr_mode, acq_pend;

  wire [HDR_BITS-1:0] hdr    = {hsr, shift_in};
  wire [ADDR_W-1:0]   h_addr = hdr[HDR_BITS-1 -: ADDR_W];
  wire [REG_W-1:0]    h_reg  = hdr[OP_W +: REG_W];
  wire [OP_W-1:0]     h_op   = hdr[OP_W-1:0];
  wire                h_hit  = (h_addr == BCAST_ID) || (h_addr == (id_bonded ? chip_id : FLOAT_ID));
  wire                h_ok   = h_hit && legal(kind_of(h_reg), h_op);
  wire                h_acq  = h_ok && h_reg == CAP_REG && h_op == OP_SET;

  // capture side: falling edges
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; hsr <= '0; dcnt <= '0; dlen <= '0;
      hreg <= '0; hop <= '0;
      hdr_new <= 1'b0; dat_new <= 1'b0; dat_bit <= 1'b0; dat_last <= 1'b0;
      wr_mode <= 1'b0; acq_pend <= 1'b0; acq_stb <= 1'b0;
    end else begin
      hdr_new <= 1'b0;
      dat_new <= 1'b0;
      acq_stb <= 1'b0;
      if (!sc_r) begin
        hcnt <= '0;
        dcnt <= '0;
        wr_mode <= 1'b0;
        if (acq_pend) begin
          acq_stb  <= 1'b1;
          acq_pend <= 1'b0;
        end
      end else if (hcnt != CNT_W'(HDR_BITS)) begin
        hsr  <= {hsr[HDR_BITS-3:0], shift_in};
        hcnt <= hcnt + 1'b1;
        if (hcnt == CNT_W'(HDR_BITS - 1)) begin
          hdr_new <= h_ok && !h_acq;
          hreg    <= h_reg;
          hop     <= h_op;
          wr_mode <= h_ok && h_op == OP_WRITE;
          dlen    <= len_of(kind_of(h_reg));
          dcnt    <= '0;
          if (h_acq) acq_pend <= 1'b1;
        end
      end else if (wr_mode && dcnt != dlen) begin
        dat_new  <= 1'b1;
        dat_bit  <= shift_in;
        dat_last <= (dcnt == dlen - DCNT_W'(1));
        dcnt     <= dcnt + 1'b1;
      end
    end
  end

  // strobe side: rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_r <= 1'b0; reg_sel <= '0;
      set_stb <= 1'b0; clr_stb <= 1'b0; dflt_stb <= 1'b0; rd_req <= 1'b0;
      wr_en <= 1'b0; wr_bit <= 1'b0; wr_last <= 1'b0;
      rd_adv <= 1'b0; shift_out <= 1'b0;
    end else begin
      sc_r      <= shift_ctl;
      set_stb   <= hdr_new && hop == OP_SET;
      clr_stb   <= hdr_new && hop == OP_CLR;
      dflt_stb  <= hdr_new && hop == OP_DFLT;
      rd_req    <= hdr_new && hop == OP_READ;
      if (hdr_new) reg_sel <= hreg;
      wr_en     <= dat_new;
      wr_bit    <= dat_new && dat_bit;
      wr_last   <= dat_new && dat_last;
      rd_adv    <= shift_ctl && (rd_req || rd_adv);
      shift_out <= shift_ctl && rd_adv && rd_bit;
    end
  end

  p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_stb, clr_stb, dflt_stb, rd_req, wr_en}));

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb || dflt_stb) |=> !(set_stb || clr_stb || dflt_stb));

  p_no_spill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> !wr_en);

  p_out_needs_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    shift_out |-> $past(rd_adv));

  p_capture_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acq_stb |=> !acq_stb);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_r && !$past(sc_r)) |-> !(set_stb || clr_stb || dflt_stb || rd_req || wr_en));
endmodule

// File: tb/test_cmd_link_decoder.sv
module test_cmd_link_decoder;
  localparam int ARRAY = 2816;
  localparam logic [31:0] RPAT = 32'hC3A5_96E1;

  logic clk = 1'b0, rst_n = 1'b0, shift_ctl = 1'b0, shift_in = 1'b0;
  logic [4:0] chip_id = 5'b00110;
  logic id_bonded = 1'b1, rd_bit = 1'b0;
  logic [4:0] reg_sel;
  logic set_stb, clr_stb, dflt_stb, wr_en, wr_bit, wr_last, rd_req, rd_adv, shift_out, acq_stb;

  cmd_link_decoder i_cmd_link_decoder (
    .clk(clk), .rst_n(rst_n), .shift_ctl(shift_ctl), .shift_in(shift_in),
    .chip_id(chip_id), .id_bonded(id_bonded), .rd_bit(rd_bit), .reg_sel(reg_sel),
    .set_stb(set_stb), .clr_stb(clr_stb), .dflt_stb(dflt_stb), .wr_en(wr_en),
    .wr_bit(wr_bit), .wr_last(wr_last), .rd_req(rd_req), .rd_adv(rd_adv),
    .shift_out(shift_out), .acq_stb(acq_stb));

  always #10 clk = ~clk;

  int cyc = 0, nvec = 0, nbad = 0, ptr = 0;
  bit run = 0, adv_prev = 0, ended = 0;
  string scen = "R10";
  bit e_set[int], e_clr[int], e_dfl[int], e_rd[int], e_adv[int], e_out[int];
  bit e_wr[int], e_wb[int], e_wl[int], e_acq[int];
  int e_sel[int];

  task automatic chk(input string req, input string nm, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s [%s] %s: got %0d expected %0d (cycle %0d)", req, scen, nm, got, exp, cyc);
    end
  endtask

  function automatic int plen(input int r);
    if (r == 16) return 2;
    if (r == 17 || r == 18) return ARRAY;
    if (r >= 1 && r <= 15 && r != 8) return 8;
    return 0;
  endfunction

  function automatic bit legal(input int r, input int op);
    case (op)
      1, 4:    return plen(r) != 0;
      2:       return plen(r) != 0 || r == 19 || r == 20 || r == 21 || r == 24 || r == 28;
      5, 6:    return plen(r) != 0 || r == 19 || r == 20 || r == 21;
      default: return 0;
    endcase
  endfunction

  task automatic predict(input int c, input logic [4:0] a, input logic [4:0] r,
                         input logic [2:0] op, input int hold, input logic [31:0] dpat);
    int s, n;
    bit hit;
    s = c + 14;
    hit = (a == 5'b10101) || (a == (id_bonded ? chip_id : 5'b01010));
    if (!hit || hold < 13 || !legal(int'(r), int'(op))) return;
    if (op == 3'b010 && r == 5'd15) begin e_acq[c + hold + 2] = 1; return; end
    case (op)
      3'b010: begin e_set[s] = 1; e_sel[s] = int'(r); end
      3'b101: begin e_clr[s] = 1; e_sel[s] = int'(r); end
      3'b110: begin e_dfl[s] = 1; e_sel[s] = int'(r); end
      3'b100: begin
        e_rd[s] = 1; e_sel[s] = int'(r);
        for (int m = c + 15; m <= c + hold; m++) e_adv[m] = 1;
        for (int m = c + 16; m <= c + hold; m++) e_out[m] = RPAT[(m - c - 16) % 32];
      end
      3'b001: begin
        n = plen(int'(r));
        if (hold - 13 < n) n = hold - 13;
        for (int j = 0; j < n; j++) begin
          e_wr[c + 15 + j] = 1;
          e_wb[c + 15 + j] = dpat[j % 32];
          e_wl[c + 15 + j] = (j == plen(int'(r)) - 1);
          e_sel[c + 15 + j] = int'(r);
        end
      end
      default: ;
    endcase
  endtask

  task automatic frame(input logic [4:0] a, input logic [4:0] r, input logic [2:0] op,
                       input int hold, input logic [31:0] dpat);
    logic [12:0] h;
    h = {a, r, op};
    @(posedge clk); #15;
    predict(cyc, a, r, op, hold, dpat);
    for (int i = 0; i < hold; i++) begin
      if (i > 0) begin @(posedge clk); #15; end
      shift_ctl = 1'b1;
      shift_in  = (i < 13) ? h[12 - i] : dpat[(i - 13) % 32];
    end
    @(posedge clk); #15;
    shift_ctl = 1'b0;
    shift_in  = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  // per-cycle comparison against the model, plus the register-bank stand-in
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      if (run) begin
        chk("R3", "set_stb",  int'(set_stb),  e_set.exists(cyc) ? 1 : 0);
        chk("R3", "clr_stb",  int'(clr_stb),  e_clr.exists(cyc) ? 1 : 0);
        chk("R3", "dflt_stb", int'(dflt_stb), e_dfl.exists(cyc) ? 1 : 0);
        chk("R4", "wr_en",    int'(wr_en),    e_wr.exists(cyc) ? 1 : 0);
        chk("R4", "wr_bit",   int'(wr_bit),   e_wb.exists(cyc) ? int'(e_wb[cyc]) : 0);
        chk("R4", "wr_last",  int'(wr_last),  e_wl.exists(cyc) ? int'(e_wl[cyc]) : 0);
        chk("R5", "rd_req",   int'(rd_req),   e_rd.exists(cyc) ? 1 : 0);
        chk("R5", "rd_adv",   int'(rd_adv),   e_adv.exists(cyc) ? 1 : 0);
        chk("R11", "shift_out", int'(shift_out), e_out.exists(cyc) ? int'(e_out[cyc]) : 0);
        chk("R6", "acq_stb",  int'(acq_stb),  e_acq.exists(cyc) ? 1 : 0);
        if (e_sel.exists(cyc)) chk("R1", "reg_sel", int'(reg_sel), e_sel[cyc]);
      end
      if (rd_req) ptr = 0;
      else if (adv_prev) ptr++;
      rd_bit = RPAT[ptr % 32];
      adv_prev = rd_adv;
    end
  end

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    finish_run();
  end

  initial begin
    #25;
    scen = "R10";
    chk("R10", "outputs in reset",
        int'({set_stb, clr_stb, dflt_stb, wr_en, wr_bit, wr_last, rd_req, rd_adv, shift_out, acq_stb}), 0);
    chk("R10", "reg_sel in reset", int'(reg_sel), 0);
    #10 rst_n = 1'b1;
    run = 1;

    scen = "R1 R3 strap set";       frame(5'b00110, 5'd3, 3'b010, 13, 0);
    scen = "R3 broadcast clear";    frame(5'b10101, 5'd17, 3'b101, 13, 0);
    scen = "R3 broadcast default";  frame(5'b10101, 5'd21, 3'b110, 16, 0);
    scen = "R2 float id while bonded"; frame(5'b01010, 5'd3, 3'b010, 13, 0);
    scen = "R2 foreign address";    frame(5'b11111, 5'd4, 3'b101, 13, 0);
    id_bonded = 1'b0;
    scen = "R2 float id unbonded";  frame(5'b01010, 5'd6, 3'b110, 13, 0);
    scen = "R2 strap id unbonded";  frame(5'b00110, 5'd6, 3'b010, 13, 0);
    id_bonded = 1'b1;

    scen = "R4 byte write overrun"; frame(5'b00110, 5'd5, 3'b001, 13 + 12, 32'hA5C3_0F96);
    scen = "R4 mode write";         frame(5'b10101, 5'd16, 3'b001, 13 + 5, 32'h0000_0002);
    scen = "R4 array write";        frame(5'b00110, 5'd18, 3'b001, 13 + ARRAY + 3, 32'h9E37_79B9);
    scen = "R4 R7 cut write";       frame(5'b00110, 5'd9, 3'b001, 13 + 3, 32'hFFFF_FFFF);

    scen = "R5 R11 byte read";      frame(5'b00110, 5'd7, 3'b100, 13 + 12, 0);
    scen = "R5 R11 long read";      frame(5'b10101, 5'd17, 3'b100, 60, 0);
    scen = "R5 short hold read";    frame(5'b00110, 5'd2, 3'b100, 14, 0);

    scen = "R6 capture at release";  frame(5'b00110, 5'd15, 3'b010, 13, 0);
    scen = "R6 capture held late";   frame(5'b10101, 5'd15, 3'b010, 22, 0);
    scen = "R6 clear of capture reg"; frame(5'b00110, 5'd15, 3'b101, 13, 0);

    scen = "R7 aborted header";      frame(5'b00110, 5'd3, 3'b010, 8, 0);
    scen = "R7 frame after abort";   frame(5'b00110, 5'd12, 3'b110, 13, 0);

    scen = "R8 write to flag";       frame(5'b00110, 5'd19, 3'b001, 23, 32'hFFFF_FFFF);
    scen = "R8 read broadcast reg";  frame(5'b00110, 5'd21, 3'b100, 20, 0);
    scen = "R8 unused reg 8";        frame(5'b00110, 5'd8, 3'b010, 13, 0);
    scen = "R8 forbidden reg 0";     frame(5'b00110, 5'd0, 3'b010, 13, 0);
    scen = "R8 forbidden reg 31";    frame(5'b10101, 5'd31, 3'b101, 13, 0);
    scen = "R8 unused reg 26";       frame(5'b10101, 5'd26, 3'b010, 13, 0);
    scen = "R8 action set 24";       frame(5'b00110, 5'd24, 3'b010, 13, 0);
    scen = "R8 action clear 24";     frame(5'b00110, 5'd24, 3'b101, 13, 0);
    scen = "R8 action set 28";       frame(5'b10101, 5'd28, 3'b010, 13, 0);
    scen = "R8 flag set 20";         frame(5'b00110, 5'd20, 3'b010, 13, 0);

    scen = "R9 op 000";              frame(5'b00110, 5'd3, 3'b000, 13, 0);
    scen = "R9 op 011";              frame(5'b00110, 5'd3, 3'b011, 13, 0);
    scen = "R9 op 111";              frame(5'b10101, 5'd3, 3'b111, 20, 0);

    repeat (4) @(posedge clk);
    #5;
    finish_run();
  end
endmodule